// File: doc/BRIEF.md
# Pipelined Two-Port RAM with Overlap Hazard Classification

This block is a memory with one write port and one read port. Both ports are pipelined. A write is accepted on a cycle where its strobe is high and reaches the storage array at the end of the third cycle, counting the request cycle as the first. A read is accepted on its own strobe and presents its result two cycles after the request. A new operation may start on either port in every cycle, so reads and writes to the same word can be in flight together.

To make that overlap predictable, the block keeps a three-deep history of the writes still moving through the pipe. When a read samples the array, it compares its address against the write that starts in that cycle and against each tracked write. From those matches it labels the returned word as settled, pre-write, just-written or unknown.

Only one case is treated as a hazard: a read that starts exactly one cycle after a write to the same word. That read would sample the array in the same cycle the write lands. The block returns no data for it, drops the known flag and raises a one-cycle warning. The write itself still completes.

Top module: `pipe_hazard_ram`

## Requirements
- R1: A read requested in cycle k raises `rd_done` for exactly one cycle, in cycle k+2. `rd_done` is low in every cycle that is not two cycles after a read request.
- R2: A write requested in cycle w updates the array at the end of cycle w+2. A read to the same address started in cycle w+2 returns the new word with `rd_known`=1, `rd_warn`=0 and `rd_class`=2 (just-written). A read started later with no other same-address write in flight returns the new word with `rd_class`=0 (settled).
- R3: A read and a write started in the same cycle behave as follows, and neither raises `rd_warn`. For the same address, the read returns the pre-write word with `rd_class`=1, and the write's word is visible afterwards. For different addresses, the read returns its own address's word with `rd_class`=0.
- R4: A read started one cycle after a write to the same address returns `rd_known`=0, `rd_data`=0 and `rd_class`=3 (unknown). `rd_warn` is high in the cycle of that result only. The write still commits, and later reads return its word.
- R5: A read started one cycle after a write to a different address is unaffected: `rd_known`=1, `rd_warn`=0, `rd_class`=0, and it returns the stored word of the read address.
- R6: A read started one cycle before a write to the same address returns the pre-write word with `rd_known`=1, `rd_class`=1 and no warning. The write commits normally.
- R7: When several same-address writes overlap one read, the class priority is unknown (3) over just-written (2) over pre-write (1) over settled (0). The data is the array contents the read samples, or 0 when the class is unknown.
- R8: Writes may be requested in consecutive cycles. Every one of them commits in request order, so the last write to an address determines its stored word.
- R9: Reset clears `rd_done`, `rd_known`, `rd_warn` and `rd_class` to 0. It also discards writes that are still in flight, so those writes never reach the array. Array contents written before reset are retained.
- R10: `rd_warn` is high only together with `rd_done`=1 and `rd_known`=0. While `rd_done`=0, the outputs `rd_known`, `rd_warn` and `rd_class` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Starts a write in this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_req | input | 1 | Starts a read in this cycle |
| rd_addr | input | ADDR_W | Read address |
| rd_done | output | 1 | A read result is presented this cycle |
| rd_known | output | 1 | The presented word is defined |
| rd_data | output | DATA_W | Read word (0 when unknown) |
| rd_class | output | 2 | 0 settled, 1 pre-write, 2 just-written, 3 unknown |
| rd_warn | output | 1 | Warning for a read racing a write commit |

## Verification
The hardest situation to create is a read that overlaps two writes to the same word at once. In that case the priority between the racing write and an already committed write decides the class. The stimulus builds it by issuing two back-to-back writes to one address and a read in the following cycle. A second case pairs a write two cycles ahead with a same-cycle write and read. The discarded in-flight write is reached by pulsing reset in the cycle after a write request and then reading the address.

// File: rtl/phr_pkg.sv
package phr_pkg;

  // Classification of a returned read word
  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_OLD   = 2'd1,
    CLS_NEW   = 2'd2,
    CLS_UNK   = 2'd3
  } rd_class_e;

  // Depth of the write history; a write lands from stage COMMIT_STG
  localparam int WR_HIST    = 3;
  localparam int COMMIT_STG = 1;

  // Priority: racing commit, then just committed, then pending write
  function automatic rd_class_e pick_class(input logic race,
                                           input logic landed,
                                           input logic pending);
    if (race)         return CLS_UNK;
    else if (landed)  return CLS_NEW;
    else if (pending) return CLS_OLD;
    else              return CLS_CLEAN;
  endfunction

  function automatic logic class_known(input rd_class_e c);
    return (c != CLS_UNK);
  endfunction

endpackage

// File: rtl/phr_wr_track.sv
module phr_wr_track #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NSTG   = phr_pkg::WR_HIST
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NSTG-1:0]             trk_vld,
  output logic [NSTG-1:0][ADDR_W-1:0] trk_addr,
  output logic                        commit_en,
  output logic [ADDR_W-1:0]           commit_addr,
  output logic [DATA_W-1:0]           commit_data
);
  localparam int CST  = phr_pkg::COMMIT_STG;
  localparam int DSTG = CST + 1;

  logic [DSTG-1:0][DATA_W-1:0] trk_data;

  // Head of the history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_vld[0]  <= 1'b0;
      trk_addr[0] <= '0;
      trk_data[0] <= '0;
    end else begin
      trk_vld[0]  <= wr_req;
      trk_addr[0] <= wr_addr;
      trk_data[0] <= wr_data;
    end
  end

  // Address/valid history for all stages
  for (genvar i = 1; i < NSTG; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trk_vld[i]  <= 1'b0;
        trk_addr[i] <= '0;
      end else begin
        trk_vld[i]  <= trk_vld[i-1];
        trk_addr[i] <= trk_addr[i-1];
      end
    end
  end

  // Data is only carried up to the commit stage
  for (genvar j = 1; j < DSTG; j++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trk_data[j] <= '0;
      else        trk_data[j] <= trk_data[j-1];
    end
  end

  assign commit_en   = trk_vld[CST];
  assign commit_addr = trk_addr[CST];
  assign commit_data = trk_data[CST];

endmodule

// File: rtl/phr_store.sv
module phr_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/phr_rd_pipe.sv
module phr_rd_pipe #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NSTG   = phr_pkg::WR_HIST
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic                        wr_req,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [NSTG-1:0]             trk_vld,
  input  logic [NSTG-1:0][ADDR_W-1:0] trk_addr,
  output logic [ADDR_W-1:0]           mem_raddr,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        race_hit,
  output logic                        landed_hit,
  output logic                        pending_hit,
  output logic                        rd_done,
  output logic                        rd_known,
  output logic [DATA_W-1:0]           rd_data,
  output logic [1:0]                  rd_class,
  output logic                        rd_warn
);
  import phr_pkg::*;

  // History stage index by start offset of the write relative to the read
  localparam int OFF_SAME = 0;
  localparam int OFF_RACE = phr_pkg::COMMIT_STG;
  localparam int OFF_DONE = OFF_RACE + 1;

  logic              s1_vld;
  logic [ADDR_W-1:0] s1_addr;
  logic [NSTG-1:0]   stg_hit;
  logic              next_hit;
  rd_class_e         cls;
  rd_class_e         o_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_vld <= rd_req;
      if (rd_req) s1_addr <= rd_addr;
    end
  end

  // Compare the sampling read with every tracked write
  for (genvar i = 0; i < NSTG; i++) begin : g_cmp
    assign stg_hit[i] = trk_vld[i] && (trk_addr[i] == s1_addr);
  end

  // Write starting one cycle after the read
  assign next_hit    = wr_req && (wr_addr == s1_addr);

  assign race_hit    = s1_vld && stg_hit[OFF_RACE];
  assign landed_hit  = s1_vld && stg_hit[OFF_DONE];
  assign pending_hit = s1_vld && (stg_hit[OFF_SAME] || next_hit);
  assign cls         = pick_class(race_hit, landed_hit, pending_hit);
  assign mem_raddr   = s1_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done  <= 1'b0;
      rd_known <= 1'b0;
      rd_warn  <= 1'b0;
      o_cls    <= CLS_CLEAN;
      rd_data  <= '0;
    end else begin
      rd_done  <= s1_vld;
      rd_known <= s1_vld && class_known(cls);
      rd_warn  <= s1_vld && !class_known(cls);
      o_cls    <= s1_vld ? cls : CLS_CLEAN;
      if (s1_vld) rd_data <= class_known(cls) ? mem_rdata : '0;
    end
  end

  assign rd_class = o_cls;

endmodule

// File: rtl/pipe_hazard_ram.sv
module pipe_hazard_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic              rd_known,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_class,
  output logic              rd_warn
);
  localparam int NSTG = phr_pkg::WR_HIST;

  logic [NSTG-1:0]             trk_vld;
  logic [NSTG-1:0][ADDR_W-1:0] trk_addr;
  logic                        commit_en;
  logic [ADDR_W-1:0]           commit_addr;
  logic [DATA_W-1:0]           commit_data;
  logic [ADDR_W-1:0]           mem_raddr;
  logic [DATA_W-1:0]           mem_rdata;
  logic                        race_hit;
  logic                        landed_hit;
  logic                        pending_hit;

  phr_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTG(NSTG)) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .trk_vld(trk_vld), .trk_addr(trk_addr),
    .commit_en(commit_en), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  phr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(commit_en), .waddr(commit_addr), .wdata(commit_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  phr_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTG(NSTG)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr),
    .trk_vld(trk_vld), .trk_addr(trk_addr),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .race_hit(race_hit), .landed_hit(landed_hit), .pending_hit(pending_hit),
    .rd_done(rd_done), .rd_known(rd_known), .rd_data(rd_data),
    .rd_class(rd_class), .rd_warn(rd_warn)
  );

endmodule

// File: rtl/pipe_hazard_ram_chk.sv
module pipe_hazard_ram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              rd_req,
  input logic              commit_en,
  input logic              race_hit,
  input logic              rd_done,
  input logic              rd_known,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        rd_class,
  input logic              rd_warn
);

  p_done_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ##2 rd_done);

  p_done_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(rd_req, 2));

  p_commit_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> $past(wr_req, 2));

  p_race_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    race_hit |=> (rd_warn && !rd_known && rd_class == 2'd3));

  p_unknown_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_known) |-> (rd_data == '0 && rd_warn));

  p_warn_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_warn |-> (rd_done && !rd_known));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> (!rd_known && !rd_warn && rd_class == 2'd0));

endmodule

bind pipe_hazard_ram pipe_hazard_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
  .commit_en(commit_en), .race_hit(race_hit),
  .rd_done(rd_done), .rd_known(rd_known), .rd_data(rd_data),
  .rd_class(rd_class), .rd_warn(rd_warn)
);

// File: tb/pipe_hazard_ram_test.sv
module pipe_hazard_ram_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rd_done, rd_known, rd_warn;
  logic [15:0] rd_data;
  logic [1:0]  rd_class;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  pipe_hazard_ram uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_known(rd_known), .rd_data(rd_data),
    .rd_class(rd_class), .rd_warn(rd_warn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // One cycle of stimulus, ending at the next falling edge
  task automatic step(input bit we, input logic [3:0] wa, input logic [15:0] wd,
                      input bit re, input logic [3:0] ra);
    wr_req = we; wr_addr = wa; wr_data = wd;
    rd_req = re; rd_addr = ra;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 4'd0, 16'd0, 0, 4'd0);
  endtask

  task automatic put(input logic [3:0] a, input logic [15:0] d);
    step(1, a, d, 0, 4'd0);
    idle(3);
  endtask

  task automatic expect_out(input string tag, input bit e_done, input bit e_known,
                            input logic [15:0] e_data, input logic [1:0] e_cls,
                            input bit e_warn);
    checks++;
    if (rd_done !== e_done || rd_known !== e_known || rd_warn !== e_warn ||
        rd_class !== e_cls || (e_done && rd_data !== e_data)) begin
      errors++;
      $display("FAIL %s: got done=%0b known=%0b data=%h class=%0d warn=%0b, expected done=%0b known=%0b data=%h class=%0d warn=%0b",
               tag, rd_done, rd_known, rd_data, rd_class, rd_warn,
               e_done, e_known, e_data, e_cls, e_warn);
    end
  endtask

  // Read issued now; result sampled two cycles later
  task automatic read_chk(input string tag, input logic [3:0] a, input logic [15:0] d,
                          input logic [1:0] cls);
    step(0, 4'd0, 16'd0, 1, a);
    idle(1);
    expect_out(tag, 1, 1, d, cls, 0);
  endtask

  task automatic t_reset_state;
    expect_out("R9 reset outputs", 0, 0, 16'h0, 2'd0, 0);
  endtask

  task automatic t_latency;
    put(4'h3, 16'h1111);
    step(0, 4'd0, 16'd0, 1, 4'h3);
    expect_out("R1 no result after one cycle", 0, 0, 16'h0, 2'd0, 0);
    idle(1);
    expect_out("R1 result after two cycles, R2 settled", 1, 1, 16'h1111, 2'd0, 0);
    idle(1);
    expect_out("R1 single-cycle done", 0, 0, 16'h0, 2'd0, 0);
  endtask

  task automatic t_offset_two;
    put(4'h5, 16'h0505);
    step(1, 4'h5, 16'h5A5A, 0, 4'd0);
    idle(1);
    step(0, 4'd0, 16'd0, 1, 4'h5);
    idle(1);
    expect_out("R2 read two after write gets new", 1, 1, 16'h5A5A, 2'd2, 0);
    idle(2);
  endtask

  task automatic t_same_cycle;
    put(4'h6, 16'h0606);
    put(4'h7, 16'h0707);
    step(1, 4'h6, 16'h6666, 1, 4'h6);
    idle(1);
    expect_out("R3 same cycle same addr old data", 1, 1, 16'h0606, 2'd1, 0);
    idle(2);
    read_chk("R3 write visible afterwards", 4'h6, 16'h6666, 2'd0);
    step(1, 4'h6, 16'h6767, 1, 4'h7);
    idle(1);
    expect_out("R3 same cycle other addr", 1, 1, 16'h0707, 2'd0, 0);
    idle(2);
  endtask

  task automatic t_offset_one;
    put(4'h8, 16'h0808);
    step(1, 4'h8, 16'h8888, 0, 4'd0);
    step(0, 4'd0, 16'd0, 1, 4'h8);
    idle(1);
    expect_out("R4 race gives unknown and warning", 1, 0, 16'h0000, 2'd3, 1);
    idle(1);
    expect_out("R4 warning lasts one cycle", 0, 0, 16'h0, 2'd0, 0);
    read_chk("R4 racing write still commits", 4'h8, 16'h8888, 2'd0);
  endtask

  task automatic t_offset_one_diff;
    put(4'hA, 16'h0A0A);
    step(1, 4'h9, 16'h9999, 0, 4'd0);
    step(0, 4'd0, 16'd0, 1, 4'hA);
    idle(1);
    expect_out("R5 different address unaffected", 1, 1, 16'h0A0A, 2'd0, 0);
    idle(2);
  endtask

  task automatic t_read_first;
    put(4'hB, 16'h0B0B);
    step(0, 4'd0, 16'd0, 1, 4'hB);
    step(1, 4'hB, 16'hBBBB, 0, 4'd0);
    expect_out("R6 read before write old data", 1, 1, 16'h0B0B, 2'd1, 0);
    idle(3);
    read_chk("R6 later write commits", 4'hB, 16'hBBBB, 2'd0);
  endtask

  task automatic t_priority;
    put(4'hC, 16'h0C0C);
    step(1, 4'hC, 16'hC001, 0, 4'd0);
    step(1, 4'hC, 16'hC002, 0, 4'd0);
    step(0, 4'd0, 16'd0, 1, 4'hC);
    idle(1);
    expect_out("R7 unknown outranks new", 1, 0, 16'h0000, 2'd3, 1);
    idle(2);
    read_chk("R7 latest write wins", 4'hC, 16'hC002, 2'd0);
    step(1, 4'hC, 16'hC003, 0, 4'd0);
    idle(1);
    step(1, 4'hC, 16'hC004, 1, 4'hC);
    idle(1);
    expect_out("R7 new outranks old", 1, 1, 16'hC003, 2'd2, 0);
    idle(2);
  endtask

  task automatic t_burst;
    step(1, 4'h0, 16'hA000, 0, 4'd0);
    step(1, 4'h1, 16'hA001, 0, 4'd0);
    step(1, 4'h2, 16'hA002, 0, 4'd0);
    step(1, 4'h1, 16'hA011, 0, 4'd0);
    idle(3);
    read_chk("R8 burst word 0", 4'h0, 16'hA000, 2'd0);
    read_chk("R8 burst last write wins", 4'h1, 16'hA011, 2'd0);
    read_chk("R8 burst word 2", 4'h2, 16'hA002, 2'd0);
  endtask

  task automatic t_reset_drop;
    put(4'hD, 16'h0D0D);
    step(1, 4'hD, 16'hDDDD, 0, 4'd0);
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R9 outputs cleared in reset", 0, 0, 16'h0, 2'd0, 0);
    rst_n = 1'b1;
    idle(3);
    read_chk("R9 in-flight write discarded", 4'hD, 16'h0D0D, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_latency();
    t_offset_two();
    t_same_cycle();
    t_offset_one();
    t_offset_one_diff();
    t_read_first();
    t_priority();
    t_burst();
    t_reset_drop();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule